// File: doc/BRIEF.md
# Centisecond Stopwatch Core

This block is a synchronous stopwatch for sports timing. It keeps elapsed time as eight BCD digits with a resolution of one hundredth of a second. The fields are hours, minutes, seconds and centiseconds. The count runs up to 23:59:59.99 and then returns to zero. A single start/stop key controls it. The key is sampled on the system clock and reduced to a one-cycle pulse, and each pulse flips an internal run flag. While the flag is set, a prescaler derived from the system clock frequency produces a 100 Hz advance strobe. While the flag is clear, both the prescaler and every digit hold still.

The block also drives a time-multiplexed eight-digit seven-segment display. A free-running scan index, paced by its own prescaler, selects one digit at a time. The segment pattern for that digit appears on a shared seven-bit bus. All rate division is done with clock enables, and every register sits on the one system clock.

Top module: `sw_stopwatch_core`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, all digits become zero, the scan index becomes 0 and the watch is stopped. After reset is released, the time stays at zero until the key is pressed.
- R2: The centisecond field counts 00 to 99 in BCD. It advances once per tick, and going from 99 to 00 carries one into the seconds field on the same edge.
- R3: The seconds and minutes fields each count 00 to 59 in BCD. Going from 59 to 00 carries into the next field on the same edge, so 00:00:59.99 is followed directly by 00:01:00.00.
- R4: The hours field counts 00 to 23. After 23:59:59.99, the next tick gives 00:00:00.00.
- R5: While running, a tick occurs once every CLK_HZ/TICK_HZ clock cycles. The prescaler is frozen while the watch is stopped, so a partial interval resumes where it left off.
- R6: The key passes through two synchronizing flip-flops. A rising edge of the key yields exactly one toggle of the run flag, however long the key is held. The flag changes at the second clock edge after the key is first sampled high.
- R7: While stopped, all eight digits keep their values.
- R8: If the toggle pulse and a tick fall on the same edge, that tick is still counted before the watch stops or starts.
- R9: The 3-bit scan index steps by one every CLK_HZ/SCAN_HZ clock cycles, wraps from 7 to 0, and keeps running whether the watch is running or stopped.
- R10: `time_bcd_o` packs nibble i at bits [4i+3:4i]. The nibbles are, from i=0 upward: centisecond units, centisecond tens, second units, second tens, minute units, minute tens, hour units, hour tens. `seg_o` shows the nibble selected by `scan_idx_o`.
- R11: `seg_o` is active high with bit 6 = g down to bit 0 = a. The digit codes are 0=0111111, 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, 7=0100111, 8=1111111, 9=1101111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low clear |
| key_i | input | 1 | Raw start/stop key, active high |
| time_bcd_o | output | 32 | Eight BCD digits of elapsed time, centisecond units in the lowest nibble |
| scan_idx_o | output | 3 | Index of the digit currently driven onto `seg_o` |
| seg_o | output | 7 | Active-high segments g..a of the selected digit |

## Verification
The bench builds the core with CLK_HZ=300, TICK_HZ=100 and SCAN_HZ=150. This gives a tick every third cycle and a scan step every second cycle. The minutes carry is then reached in about eighteen thousand cycles, and the bench can place a key pulse exactly on a tick edge. The hours wrap from 23 to 00 is exercised on a separate 24-count stage instance driven directly. The full-day rollover is covered by an assertion on the carry out of the hours stage.

// File: rtl/sw_pkg.sv
// Shared constants and helpers for the stopwatch core.
// Assumes four two-digit BCD stages, eight display digits in total.
package sw_pkg;

    localparam int NUM_STAGES = 4;
    localparam int NUM_DIGITS = 2 * NUM_STAGES;
    localparam int TIME_W     = 4 * NUM_DIGITS;

    typedef logic [7:0] bcd_pair_t;

    // Modulus of each stage, lowest (centiseconds) first.
    function automatic int stage_mod(input int idx);
        case (idx)
            0:       return 100;
            1, 2:    return 60;
            default: return 24;
        endcase
    endfunction

    // Active-high segment pattern, bit 6 = g down to bit 0 = a.
    function automatic logic [6:0] seg_code(input logic [3:0] d);
        case (d)
            4'd0:    return 7'b0111111;
            4'd1:    return 7'b0000110;
            4'd2:    return 7'b1011011;
            4'd3:    return 7'b1001111;
            4'd4:    return 7'b1100110;
            4'd5:    return 7'b1101101;
            4'd6:    return 7'b1111101;
            4'd7:    return 7'b0100111;
            4'd8:    return 7'b1111111;
            4'd9:    return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

endpackage

// File: rtl/sw_rate_div.sv
// Enable-based rate divider: asserts tick_o for one cycle every DIV
// enabled cycles. The count freezes while en_i is low.
// Assumes DIV >= 1; synchronous active-low reset.
module sw_rate_div #(
    parameter int DIV = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: terminal-count strobe while enabled.
    assign tick_o = en_i && (cnt_q == LAST);

    // Purpose: advance or hold the divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R5
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/sw_key_pulse.sv
// Two-flop synchronizer on the raw key, followed by a rising-edge
// detector that gives one pulse per press. Assumes the key is held
// longer than one clock cycle. Synchronous active-low reset.
module sw_key_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic key_i,
    output logic pulse_o
);
    logic [1:0] sync_q;

    // Purpose: shift the key through two flip-flops.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], key_i};
    end

    // Purpose: first stage high while second stage still low.
    assign pulse_o = sync_q[0] & ~sync_q[1];

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/sw_bcd_stage.sv
// Two-digit BCD counter with modulus MOD (at most 100). It advances on
// inc_i and returns to 00 after MOD-1. wrap_o is combinational, so the
// next stage moves on the same edge. Synchronous active-low reset.
module sw_bcd_stage #(
    parameter int MOD = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc_i,
    output logic [7:0] value_o,
    output logic       wrap_o
);
    localparam logic [3:0] TENS_MAX  = 4'((MOD - 1) / 10);
    localparam logic [3:0] UNITS_MAX = 4'((MOD - 1) % 10);

    logic [3:0] tens_q, units_q;
    logic       at_max;

    // Purpose: detect the last count of this stage.
    assign at_max  = (tens_q == TENS_MAX) && (units_q == UNITS_MAX);
    assign wrap_o  = inc_i && at_max;
    assign value_o = {tens_q, units_q};

    // Purpose: BCD increment with wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tens_q  <= 4'd0;
            units_q <= 4'd0;
        end else if (inc_i) begin
            if (at_max) begin
                tens_q  <= 4'd0;
                units_q <= 4'd0;
            end else if (units_q == 4'd9) begin
                tens_q  <= tens_q + 4'd1;
                units_q <= 4'd0;
            end else begin
                units_q <= units_q + 4'd1;
            end
        end
    end

    // R2, R3, R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (value_o == 8'h00));

    // R2, R3, R4
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (units_q <= 4'd9) && ((int'(tens_q) * 10 + int'(units_q)) < MOD));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !at_max) |=> (value_o != $past(value_o)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(value_o));

endmodule

// File: rtl/sw_scan_display.sv
// Display scanner: a free-running 3-bit index, stepped every SCAN_DIV
// cycles, selects one nibble of digits_i and decodes it to segments.
// Assumes eight packed nibbles, lowest first. Synchronous active-low reset.
module sw_scan_display
    import sw_pkg::*;
#(
    parameter int SCAN_DIV = 6250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] digits_i,
    output logic [2:0]        scan_o,
    output logic [6:0]        seg_o
);
    logic       step;
    logic [2:0] idx_q;

    sw_rate_div #(.DIV(SCAN_DIV)) u_scan_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (1'b1),
        .tick_o (step)
    );

    // Purpose: step the scan index, wrapping after 7.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= 3'd0;
        else if (step) idx_q <= idx_q + 3'd1;
    end

    // Purpose: select the current nibble and decode it.
    assign scan_o = idx_q;
    assign seg_o  = seg_code(digits_i[4*idx_q +: 4]);

    // R9
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (idx_q == $past(idx_q) + 3'd1));

    // R9
    scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(idx_q));

endmodule

// File: rtl/sw_stopwatch_core.sv
// Stopwatch top: key conditioning, run flag, 100 Hz tick prescaler,
// chained BCD stages (100, 60, 60, 24) and the display scanner.
// Assumes CLK_HZ is a multiple of TICK_HZ and SCAN_HZ. Single clock,
// synchronous active-low reset.
module sw_stopwatch_core
    import sw_pkg::*;
#(
    parameter int CLK_HZ  = 50000000,
    parameter int TICK_HZ = 100,
    parameter int SCAN_HZ = 8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_i,
    output logic [31:0] time_bcd_o,
    output logic [2:0]  scan_idx_o,
    output logic [6:0]  seg_o
);
    localparam int TICK_DIV = CLK_HZ / TICK_HZ;
    localparam int SCAN_DIV = CLK_HZ / SCAN_HZ;

    logic                  toggle;
    logic                  run_q;
    logic                  tick;
    logic [NUM_STAGES:0]   carry;
    logic [TIME_W-1:0]     time_bcd;

    sw_key_pulse u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_i   (key_i),
        .pulse_o (toggle)
    );

    // Purpose: run flag flips once per key pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (toggle) run_q <= ~run_q;
    end

    sw_rate_div #(.DIV(TICK_DIV)) u_tick_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (run_q),
        .tick_o (tick)
    );

    // Purpose: chain the stages so carries ripple within one edge.
    assign carry[0] = tick;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        bcd_pair_t pair;
        sw_bcd_stage #(.MOD(stage_mod(i))) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (carry[i]),
            .value_o (pair),
            .wrap_o  (carry[i+1])
        );
        assign time_bcd[8*i +: 8] = pair;
    end

    assign time_bcd_o = time_bcd;

    sw_scan_display #(.SCAN_DIV(SCAN_DIV)) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .digits_i (time_bcd),
        .scan_o   (scan_idx_o),
        .seg_o    (seg_o)
    );

    // R4
    day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry[NUM_STAGES] |=> (time_bcd_o == 32'h0));

    // R6
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (run_q != $past(run_q)));

    // R7
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> $stable(time_bcd_o));

    // R8
    coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && toggle) |=> (!run_q && (time_bcd_o != $past(time_bcd_o))));

endmodule

// File: tb/sw_stopwatch_core_bench.sv
`timescale 1ns/1ps
module sw_stopwatch_core_bench;

    localparam int CLK_HZ   = 300;
    localparam int TICK_HZ  = 100;
    localparam int SCAN_HZ  = 150;
    localparam int TDIV     = CLK_HZ / TICK_HZ;
    localparam int SDIV     = CLK_HZ / SCAN_HZ;
    localparam int DAY      = 8640000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key = 1'b0;
    logic [31:0] time_bcd;
    logic [2:0]  scan_idx;
    logic [6:0]  seg;

    logic        st_rst_n = 1'b0;
    logic        st_inc = 1'b0;
    logic [7:0]  st_val;
    logic        st_wrap;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // behavioural reference state
    int m_t = 0, m_run = 0, m_pc = 0, m_s1 = 0, m_s2 = 0, m_sc = 0, m_idx = 0;

    always #2 clk = ~clk;

    sw_stopwatch_core #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .SCAN_HZ(SCAN_HZ)) u_sw_stopwatch_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_i      (key),
        .time_bcd_o (time_bcd),
        .scan_idx_o (scan_idx),
        .seg_o      (seg)
    );

    sw_bcd_stage #(.MOD(24)) u_hour_stage (
        .clk     (clk),
        .rst_n   (st_rst_n),
        .inc_i   (st_inc),
        .value_o (st_val),
        .wrap_o  (st_wrap)
    );

    function automatic logic [31:0] to_bcd(input int t);
        int h, m, s, c;
        h = t / 360000;
        m = (t / 6000) % 60;
        s = (t / 100) % 60;
        c = t % 100;
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10),
                4'(s / 10), 4'(s % 10), 4'(c / 10), 4'(c % 10)};
    endfunction

    function automatic logic [6:0] seg_ref(input int v);
        case (v)
            0: return 7'b0111111;  1: return 7'b0000110;
            2: return 7'b1011011;  3: return 7'b1001111;
            4: return 7'b1100110;  5: return 7'b1101101;
            6: return 7'b1111101;  7: return 7'b0100111;
            8: return 7'b1111111;  9: return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic press();
        key = 1'b1;
        @(negedge clk);
        key = 1'b0;
    endtask

    // reference model: advance on each clock edge from pre-edge state
    always @(posedge clk) begin
        int pulse, tick, sstep;
        cyc++;
        if (!rst_n) begin
            m_t = 0; m_run = 0; m_pc = 0; m_s1 = 0; m_s2 = 0; m_sc = 0; m_idx = 0;
        end else begin
            pulse = (m_s1 == 1 && m_s2 == 0);
            tick  = (m_run == 1 && m_pc == TDIV - 1);
            if (m_run == 1) m_pc = tick ? 0 : m_pc + 1;
            if (tick) m_t = (m_t + 1) % DAY;
            if (pulse) m_run = 1 - m_run;
            m_s2 = m_s1;
            m_s1 = key ? 1 : 0;
            sstep = (m_sc == SDIV - 1);
            m_sc = sstep ? 0 : m_sc + 1;
            if (sstep) m_idx = (m_idx + 1) % 8;
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [31:0] e;
        if (cyc >= 1) begin
            e = to_bcd(m_t);
            chk(time_bcd[7:0] == e[7:0], "R2 centiseconds", {24'h0, time_bcd[7:0]}, {24'h0, e[7:0]});
            chk(time_bcd[23:8] == e[23:8], "R3 seconds/minutes", {16'h0, time_bcd[23:8]}, {16'h0, e[23:8]});
            chk(time_bcd[31:24] == e[31:24], "R4 hours", {24'h0, time_bcd[31:24]}, {24'h0, e[31:24]});
            chk(int'(scan_idx) == m_idx, "R9 scan index", {29'h0, scan_idx}, 32'(m_idx));
            chk(seg == seg_ref(int'(e[4*m_idx +: 4])), "R10 selected digit", {25'h0, seg},
                {25'h0, seg_ref(int'(e[4*m_idx +: 4]))});
        end
    end

    initial begin
        logic [31:0] snap;
        logic [2:0]  sidx;
        int n, t0;

        repeat (3) @(negedge clk);
        chk(time_bcd == 32'h0, "R1 digits cleared", time_bcd, 32'h0);
        chk(scan_idx == 3'd0, "R1 scan cleared", {29'h0, scan_idx}, 32'h0);
        chk(seg == 7'b0111111, "R11 code for 0", {25'h0, seg}, 32'h3f);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(time_bcd == 32'h0, "R1 stopped after reset", time_bcd, 32'h0);

        // start and measure tick spacing
        press();
        repeat (30) @(negedge clk);
        snap = time_bcd; n = 0;
        while (time_bcd == snap && n < 20) begin @(negedge clk); n++; end
        snap = time_bcd; n = 0;
        while (time_bcd == snap && n < 20) begin @(negedge clk); n++; end
        chk(n == TDIV, "R5 tick spacing", 32'(n), 32'(TDIV));

        // scan pacing and wrap
        sidx = scan_idx; n = 0;
        while (scan_idx == sidx && n < 20) begin @(negedge clk); n++; end
        sidx = scan_idx; n = 0;
        while (scan_idx == sidx && n < 20) begin @(negedge clk); n++; end
        chk(n == SDIV, "R9 scan spacing", 32'(n), 32'(SDIV));
        n = 0;
        while (scan_idx != 3'd7 && n < 40) begin @(negedge clk); n++; end
        while (scan_idx == 3'd7 && n < 80) begin @(negedge clk); n++; end
        chk(scan_idx == 3'd0, "R9 scan wrap", {29'h0, scan_idx}, 32'h0);
        chk(seg == seg_ref(int'(time_bcd[3:0])), "R11 code of centisecond units",
            {25'h0, seg}, {25'h0, seg_ref(int'(time_bcd[3:0]))});

        // stop and hold
        press();
        repeat (5) @(negedge clk);
        snap = time_bcd;
        repeat (40) @(negedge clk);
        chk(time_bcd == snap, "R7 hold while stopped", time_bcd, snap);

        // long press gives one toggle
        key = 1'b1;
        repeat (40) @(negedge clk);
        key = 1'b0;
        snap = time_bcd;
        repeat (30) @(negedge clk);
        chk(time_bcd != snap, "R6 long press starts once", time_bcd, snap);
        chk(time_bcd == to_bcd(m_t), "R6 count after long press", time_bcd, to_bcd(m_t));

        // key pulse landing on a tick edge
        n = 0;
        while (m_pc != TDIV - 2 && n < 20) begin @(negedge clk); n++; end
        t0 = m_t;
        press();
        repeat (10) @(negedge clk);
        chk(time_bcd == to_bcd(t0 + 1), "R8 coincident tick counted", time_bcd, to_bcd(t0 + 1));

        // run to the seconds and minutes carries
        press();
        n = 0;
        while (m_t < 100 && n < 2000) begin @(negedge clk); n++; end
        chk(time_bcd == 32'h00000100, "R2 carry into seconds", time_bcd, 32'h00000100);
        n = 0;
        while (m_t < 6000 && n < 30000) begin @(negedge clk); n++; end
        chk(time_bcd == 32'h00010000, "R3 carry into minutes", time_bcd, 32'h00010000);

        // reset while running
        rst_n = 1'b0;
        @(negedge clk);
        chk(time_bcd == 32'h0, "R1 mid-run clear", time_bcd, 32'h0);
        chk(scan_idx == 3'd0, "R1 mid-run scan clear", {29'h0, scan_idx}, 32'h0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(time_bcd == 32'h0, "R1 stopped after mid-run clear", time_bcd, 32'h0);

        // hours stage wrap on a standalone 24-count stage
        @(negedge clk);
        st_rst_n = 1'b1;
        st_inc = 1'b1;
        repeat (23) @(negedge clk);
        chk(st_val == 8'h23, "R4 hours reach 23", {24'h0, st_val}, 32'h23);
        chk(st_wrap == 1'b1, "R4 hours carry out", {31'h0, st_wrap}, 32'h1);
        @(negedge clk);
        chk(st_val == 8'h00, "R4 hours wrap to 00", {24'h0, st_val}, 32'h0);
        st_inc = 1'b0;
        repeat (3) @(negedge clk);
        chk(st_val == 8'h00, "R4 hours hold without advance", {24'h0, st_val}, 32'h0);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule